// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit counts what a processor core is doing. It holds one control word, one cycle counter and two event counters. Each event counter watches one line of a 256-line bus of single-cycle event pulses. The line it watches is chosen by an 8-bit selector field in the control word. A small register port reads and writes the control word and loads any of the counters directly, so software can preload a counter close to its limit and get an interrupt after a chosen number of events.

The cycle counter can count every core clock, or once every 64 core clocks through a 6-bit prescaler. When a counter passes its maximum it wraps to zero and keeps counting. The wrap also sets a sticky overflow flag for that counter. A flag whose enable bit is set drives the interrupt line. Both counter clears are one-shot command bits in the control word.

Top module: `pmu_unit`

## Requirements
- R1: While control bit 0 (global enable) is 0, neither the cycle counter, its prescaler nor the event counters advance.
- R2: Writing the control word with bit 1 set zeroes both event counters on the next edge. Writing it with bit 2 set zeroes the cycle counter and the prescaler. Both bits always read back as 0.
- R3: While control bit 3 is 1, the cycle counter advances once every 64 enabled clocks. While bit 3 is 0, it advances on every enabled clock.
- R4: Control bits 19:12 pick the event line for event counter 0, and bits 27:20 pick it for event counter 1. An enabled counter adds 1 in each cycle its chosen line is high.
- R5: A counter that advances from all-ones wraps to 0 and keeps counting. The wrap sets an overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly when some flag (bits 8, 9, 10) is set together with its enable (bits 4, 5, 6 respectively).
- R8: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. `rdData` shows the indexed register in the same cycle. A write to index 1 to 3 loads that counter, and the load takes precedence over counting.
- R9: The control word reads back bits 0, 3 to 6, 8 to 10 and 12 to 27 as held. All other bits read as 0.
- R10: After reset, every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regIdx | input | 2 | Register index for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the indexed register |
| events | input | 256 | Single-cycle event pulses |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a 32-bit wrap, especially one that lands in the same cycle as a flag clear or a counter clear. Counting up from zero would take billions of cycles. The stimulus therefore preloads counters to a few values below all-ones and then runs random event traffic. Directed steps place a flag-clear write exactly on the wrap cycle and let the divided cycle counter cross a 64-clock boundary from a preloaded value.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 8;
  localparam int NUM_EVT = 2;
  localparam int PRE_W   = 6;
  localparam int EVT_LINES = 1 << SEL_W;

  // Control-word bit positions
  localparam int B_EN     = 0;
  localparam int B_RSTEVT = 1;
  localparam int B_RSTCLK = 2;
  localparam int B_DIV    = 3;
  localparam int B_IE     = 4;
  localparam int B_FLG    = 8;
  localparam int B_SEL    = 12;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CLK  = 2'd1,
    IDX_EVT0 = 2'd2,
    IDX_EVT1 = 2'd3
  } regIdx_e;

  typedef struct packed {
    logic                          enable;
    logic                          divide;
    logic                          rstEvt;
    logic                          rstClk;
    logic                          loadClk;
    logic [NUM_EVT-1:0]            loadEvt;
    logic [NUM_EVT-1:0][SEL_W-1:0] sel;
  } pmuStrobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int DATA_W = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regIdx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_EVT:0]  wrap,
  output pmuStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq
);
  localparam int NFLG = NUM_EVT + 1;

  logic                          enable;
  logic                          divide;
  logic [NFLG-1:0]               intEn;
  logic [NFLG-1:0]               flags;
  logic [NUM_EVT-1:0][SEL_W-1:0] sel;
  logic                          ctrlWr;
  logic [NFLG-1:0]               clrMask;

  assign ctrlWr  = wrEn && (regIdx == IDX_CTRL);
  assign clrMask = ctrlWr ? wrData[B_FLG +: NFLG] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      divide <= 1'b0;
      intEn  <= '0;
      flags  <= '0;
      sel    <= '0;
    end else begin
      if (ctrlWr) begin
        enable <= wrData[B_EN];
        divide <= wrData[B_DIV];
        intEn  <= wrData[B_IE +: NFLG];
        for (int e = 0; e < NUM_EVT; e++)
          sel[e] <= wrData[B_SEL + e*SEL_W +: SEL_W];
      end
      flags <= (flags & ~clrMask) | wrap;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.enable  = enable;
    strobe.divide  = divide;
    strobe.rstEvt  = ctrlWr && wrData[B_RSTEVT];
    strobe.rstClk  = ctrlWr && wrData[B_RSTCLK];
    strobe.loadClk = wrEn && (regIdx == IDX_CLK);
    strobe.loadEvt[0] = wrEn && (regIdx == IDX_EVT0);
    strobe.loadEvt[1] = wrEn && (regIdx == IDX_EVT1);
    strobe.sel     = sel;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[B_EN]  = enable;
    ctrlWord[B_DIV] = divide;
    ctrlWord[B_IE +: NFLG]  = intEn;
    ctrlWord[B_FLG +: NFLG] = flags;
    for (int e = 0; e < NUM_EVT; e++)
      ctrlWord[B_SEL + e*SEL_W +: SEL_W] = sel[e];
  end

  assign irq = |(flags & intEn);

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrap != '0 |=> ((flags & $past(wrap)) == $past(wrap))); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && wrap == '0) |=> (flags == $past(flags))); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intEn != '0)); // R7
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int DATA_W = CNT_W,
  parameter int NLINES = EVT_LINES
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmuStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NLINES-1:0] events,
  output logic [DATA_W-1:0] clkCnt,
  output logic [DATA_W-1:0] evtCnt [NUM_EVT],
  output logic [NUM_EVT:0]  wrap
);
  logic [PRE_W-1:0] prescale;
  logic             tick;

  assign tick = strobe.enable && (!strobe.divide || (prescale == '1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale <= '0;
      clkCnt   <= '0;
    end else begin
      if (strobe.rstClk) prescale <= '0;
      else if (strobe.enable && strobe.divide) prescale <= prescale + 1'b1;
      if (strobe.loadClk)     clkCnt <= wrData;
      else if (strobe.rstClk) clkCnt <= '0;
      else if (tick)          clkCnt <= clkCnt + 1'b1;
    end
  end

  assign wrap[NUM_EVT] = tick && !strobe.loadClk && !strobe.rstClk && (clkCnt == '1);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic hit;
    assign hit = strobe.enable && events[strobe.sel[e]];
    always_ff @(posedge clk) begin
      if (!rstN)                   evtCnt[e] <= '0;
      else if (strobe.loadEvt[e])  evtCnt[e] <= wrData;
      else if (strobe.rstEvt)      evtCnt[e] <= '0;
      else if (hit)                evtCnt[e] <= evtCnt[e] + 1'b1;
    end
    assign wrap[e] = hit && !strobe.loadEvt[e] && !strobe.rstEvt && (evtCnt[e] == '1);

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.enable && !strobe.loadEvt[e] && !strobe.rstEvt) |=> (evtCnt[e] == $past(evtCnt[e]))); // R1
    AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rstEvt && !strobe.loadEvt[e]) |=> (evtCnt[e] == '0)); // R2
  end

  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enable && !strobe.loadClk && !strobe.rstClk) |=> (clkCnt == $past(clkCnt))); // R1
  AST_CLK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rstClk && !strobe.loadClk) |=> (clkCnt == '0 && prescale == '0)); // R2
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enable && strobe.divide && prescale != '1 && !strobe.loadClk && !strobe.rstClk)
      |=> (clkCnt == $past(clkCnt))); // R3
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           regIdx,
  input  logic                 wrEn,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     rdData,
  input  logic [EVT_LINES-1:0] events,
  output logic                 irq
);
  pmuStrobe_t       strobe;
  logic [NUM_EVT:0] wrap;
  logic [CNT_W-1:0] ctrlWord;
  logic [CNT_W-1:0] clkCnt;
  logic [CNT_W-1:0] evtCnt [NUM_EVT];

  pmu_ctrl #(.DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
    .wrap(wrap), .strobe(strobe), .ctrlWord(ctrlWord), .irq(irq)
  );

  pmu_datapath #(.DATA_W(CNT_W), .NLINES(EVT_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .events(events),
    .clkCnt(clkCnt), .evtCnt(evtCnt), .wrap(wrap)
  );

  always_comb begin
    unique case (regIdx)
      IDX_CTRL: rdData = ctrlWord;
      IDX_CLK:  rdData = clkCnt;
      IDX_EVT0: rdData = evtCnt[0];
      default:  rdData = evtCnt[1];
    endcase
  end

  AST_CMD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regIdx == IDX_CTRL) |-> (rdData[2:1] == 2'b00)); // R2
endmodule

// File: tb/tb_pmu_unit.sv
`timescale 1ns/100ps
module tb_pmu_unit;
  logic         clk = 0;
  logic         rstN = 0;
  logic [1:0]   regIdx = 0;
  logic         wrEn = 0;
  logic [31:0]  wrData = 0;
  logic [31:0]  rdData;
  logic [255:0] events = '0;
  logic         irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pmu_unit dut (.clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
                .rdData(rdData), .events(events), .irq(irq));

  // Reference state derived from the requirements
  logic        mEn, mDiv;
  logic [2:0]  mIe, mFlg;
  logic [7:0]  mSel0, mSel1;
  logic [5:0]  mPre;
  logic [31:0] mClk, mE0, mE1;

  function automatic logic [31:0] modelRead(input logic [1:0] idx);
    case (idx)
      2'd0: return {4'b0, mSel1, mSel0, 1'b0, mFlg, 1'b0, mIe, mDiv, 2'b00, mEn};
      2'd1: return mClk;
      2'd2: return mE0;
      default: return mE1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mDiv = 0; mIe = 0; mFlg = 0; mSel0 = 0; mSel1 = 0;
      mPre = 0; mClk = 0; mE0 = 0; mE1 = 0;
    end else begin
      automatic logic cw = wrEn && regIdx == 2'd0;
      automatic logic tick = mEn && (!mDiv || mPre == 6'h3f);
      automatic logic h0 = mEn && events[mSel0];
      automatic logic h1 = mEn && events[mSel1];
      automatic logic [2:0] wr = 3'b0;
      if (wrEn && regIdx == 2'd1) mClk = wrData;
      else if (cw && wrData[2]) mClk = 0;
      else if (tick) begin wr[2] = (mClk == '1); mClk = mClk + 1; end
      if (cw && wrData[2]) mPre = 0;
      else if (mEn && mDiv) mPre = mPre + 1;
      if (wrEn && regIdx == 2'd2) mE0 = wrData;
      else if (cw && wrData[1]) mE0 = 0;
      else if (h0) begin wr[0] = (mE0 == '1); mE0 = mE0 + 1; end
      if (wrEn && regIdx == 2'd3) mE1 = wrData;
      else if (cw && wrData[1]) mE1 = 0;
      else if (h1) begin wr[1] = (mE1 == '1); mE1 = mE1 + 1; end
      if (cw) begin
        mFlg = mFlg & ~wrData[10:8];
        mEn = wrData[0]; mDiv = wrData[3]; mIe = wrData[6:4];
        mSel0 = wrData[19:12]; mSel1 = wrData[27:20];
      end
      mFlg = mFlg | wr;
    end
  end

  task automatic cyc(input logic [1:0] idx, input logic we, input logic [31:0] wd,
                     input logic [255:0] ev);
    regIdx = idx; wrEn = we; wrData = wd; events = ev;
    @(posedge clk); #1;
    wrEn = 0; events = '0;
  endtask

  task automatic chk(input logic [1:0] idx, input string tag);
    regIdx = idx; #0.5;
    total++;
    if (rdData !== modelRead(idx)) begin
      bad++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, idx, rdData, modelRead(idx));
    end
    total++;
    if (irq !== |(mFlg & mIe)) begin
      bad++;
      $display("FAIL R7 irq actual=%b expected=%b (%s)", irq, |(mFlg & mIe), tag);
    end
  endtask

  task automatic chkVal(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    regIdx = idx; #0.5;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, idx, rdData, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    for (int i = 0; i < 4; i++) chk(i[1:0], tag);
  endtask

  function automatic logic [255:0] rndEv();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #1ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    // R10 reset state
    for (int i = 0; i < 4; i++) chkVal(i[1:0], 32'h0, "R10");
    chk(0, "R10");

    // R1: disabled, events and clocks do not count
    cyc(0, 1, 32'h0020_1000, '0);            // sel0=1 sel1=2, disabled
    repeat (5) cyc(0, 0, 0, {256{1'b1}});
    chkVal(1, 0, "R1"); chkVal(2, 0, "R1"); chkVal(3, 0, "R1");

    // R4: enable, pulse selected lines
    cyc(0, 1, 32'h0020_1001, '0);
    cyc(0, 0, 0, 256'h2);                     // line1 only
    cyc(0, 0, 0, 256'h4);                     // line2 only
    cyc(0, 0, 0, 256'h6);
    cyc(0, 0, 0, 256'h9);                     // neither
    chk(2, "R4"); chk(3, "R4");
    chkVal(2, 2, "R4"); chkVal(3, 2, "R4");

    // R5/R7: event 0 wrap with interrupt enabled
    cyc(0, 1, 32'h0020_1011, '0);
    cyc(2, 1, 32'hFFFF_FFFE, '0);
    cyc(0, 0, 0, 256'h2);
    cyc(0, 0, 0, 256'h2);
    chkVal(2, 0, "R5"); chk(0, "R5");
    total++; if (irq !== 1'b1) begin bad++; $display("FAIL R7 irq actual=%b expected=1", irq); end
    cyc(0, 0, 0, 256'h2);
    chkVal(2, 1, "R5");

    // R6: write 0 keeps flag, write 1 clears
    cyc(0, 1, 32'h0020_1011, '0);
    chk(0, "R6");
    cyc(0, 1, 32'h0020_1111, '0);
    chk(0, "R6");
    total++; if (irq !== 1'b0) begin bad++; $display("FAIL R7 irq actual=%b expected=0", irq); end
    // R6: wrap in same cycle as clear -> set wins
    cyc(2, 1, 32'hFFFF_FFFF, '0);
    cyc(0, 1, 32'h0020_1111, 256'h2);
    chk(0, "R6"); chk(2, "R6");

    // R2: one-shot clears
    cyc(0, 1, 32'h0020_1007, '0);
    chk(0, "R2"); chkVal(2, 0, "R2"); chk(1, "R2");

    // R3: divide-by-64, crossing boundaries
    cyc(0, 1, 32'h0020_100D, '0);             // enable, divide, clear clock
    repeat (130) cyc(0, 0, 0, '0);
    chk(1, "R3");
    chkVal(1, 2, "R3");
    cyc(1, 1, 32'hFFFF_FFFF, '0);
    repeat (70) cyc(0, 0, 0, '0);
    chk(1, "R3"); chk(0, "R5");

    // R8/R9: random traffic with preloads near the limit
    for (int n = 0; n < 3000; n++) begin
      automatic int r = $urandom_range(0, 19);
      if (r == 0)
        cyc(0, 1, $urandom & 32'h0FFF_FFFF, rndEv());
      else if (r == 1)
        cyc($urandom_range(1, 3), 1, 32'hFFFF_FFFF - $urandom_range(0, 6), rndEv());
      else
        cyc(0, 0, 0, rndEv());
      if (n % 7 == 0) chkAll((n % 2) ? "R8" : "R9");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule